// File: doc/BRIEF.md
# Three-Slot Serial Receive Queue with Break Marking

This block holds up to three received characters for a single serial channel. Characters arrive as a valid/data pair, and line breaks arrive as a one-cycle strobe. A processor takes characters out through a holding-register read strobe. The queue reports its free space so the upstream sender can hold back. It keeps a receive-ready status and a matching interrupt request.

A line break is turned into a 0x00 character, and a break status bit is set with it. When the processor later reads a character while that status bit is set, the bit clears and the break interrupt request is asserted. This lets software see when the marked character has been consumed. Software clears the break interrupt request with an acknowledge strobe. A receiver-clear strobe empties the queue in one cycle.

Top module: `rx_brk_queue`

## Requirements
- R1: The queue holds at most 3 characters and returns them in arrival order. Storage is addressed by a read index and a pending count, and the write slot is (index + count) modulo 3, so the index wraps 2 -> 0.
- R2: `free_slots` equals 3 minus the pending count while `rx_en` is 1, and 0 while `rx_en` is 0. It follows the count and `rx_en` combinationally.
- R3: An accepted arrival into an empty queue sets `rdy` and `rdy_irq` at the next clock edge. An arrival into a non-empty queue leaves them at 1.
- R4: A read strobe (`rd_req`) while data is pending has two effects. `rd_data` shows the oldest character one cycle later, and the count decrements. When the count reaches 0, `rdy` and `rdy_irq` clear and the index stays where it is. Otherwise the index advances modulo 3.
- R5: A read strobe with nothing pending still loads `rd_data` with the entry at the read index one cycle later. It changes no count, index or flag.
- R6: An arrival offered while `free_slots` is 0 (queue full or receiver disabled) is dropped. No overrun flag or other state is set for it.
- R7: A break strobe sets `brk_stat`. It sets `brk_irq` only if `brk_stat` was 0. It enqueues 0x00 if there is space. An `in_vld` in the same cycle is ignored.
- R8: A read that consumes data while `brk_stat` is 1 clears `brk_stat` and sets `brk_irq`. A new break strobe in that cycle keeps `brk_stat` at 1. `brk_ack` clears `brk_irq`, and a set in the same cycle wins over the acknowledge.
- R9: `rx_clr` zeroes the count and clears `rdy` and `rdy_irq` at the next edge, and keeps the read index. Any arrival or read in that cycle has no effect on the queue.
- R10: A read and an arrival in the same cycle both take effect. The read returns the oldest character held before that cycle. If the queue was empty, the read returns the stale indexed entry and the arrival becomes the only pending character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; when 0, free space reads 0 |
| rx_clr | input | 1 | Receiver clear strobe |
| in_vld | input | 1 | Incoming character valid |
| in_data | input | 8 | Incoming character |
| brk_evt | input | 1 | Line-break event strobe |
| rd_req | input | 1 | Holding-register read strobe |
| brk_ack | input | 1 | Clears the break interrupt request |
| rd_data | output | 8 | Holding-register data, valid the cycle after `rd_req` |
| free_slots | output | 2 | Free entries offered to the sender |
| rdy | output | 1 | Receive-ready status |
| rdy_irq | output | 1 | Receive-ready interrupt request |
| brk_stat | output | 1 | Break status bit |
| brk_irq | output | 1 | Break interrupt request |

## Verification
Two functions can fall in the same cycle: a holding-register read and an incoming character or break. Read-while-arrive is driven on purpose at the edge counts 0, 1 and 3. At count 1 it checks that the index still advances to the new character and that receive-ready stays set. A break is also timed onto a read that consumes an earlier break's zero. All outcomes are judged against a behavioural model in the bench that applies the read first and then the arrival, and compares every output on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Per-cycle queue events decided by the pointer logic.
  typedef struct packed {
    logic push;      // an arrival is accepted into storage
    logic pop;       // a read consumes a pending entry
    logic pop_last;  // that read takes the final pending entry
  } rxq_ev_t;
endpackage

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DEPTH = 3,
  parameter int DW    = 8,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [IW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] ram [DEPTH];

  // Simple dual-port array with a registered, read-before-write port.
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/rxq_ptr.sv
module rxq_ptr
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int IW    = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          rx_clr,
  input  logic          offer,
  input  logic          take,
  output logic [CW-1:0] count,
  output logic [IW-1:0] ridx,
  output logic [IW-1:0] waddr,
  output logic [CW-1:0] free,
  output rxq_ev_t       ev
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
  localparam logic [CW:0]   DEPTH_W = (CW+1)'(DEPTH);
  localparam logic [IW-1:0] LAST_I  = IW'(DEPTH - 1);

  logic [CW:0]   wsum;
  logic [IW-1:0] ridx_inc;
  logic          hold_idx;

  assign free        = rx_en ? (DEPTH_C - count) : '0;
  assign ev.push     = offer & (free != '0) & ~rx_clr;
  assign ev.pop      = take & (count != '0) & ~rx_clr;
  assign ev.pop_last = ev.pop & (count == CW'(1));

  // Write slot is index plus count, folded back into 0..DEPTH-1.
  assign wsum  = (CW+1)'(ridx) + (CW+1)'(count);
  assign waddr = (wsum >= DEPTH_W) ? IW'(wsum - DEPTH_W) : IW'(wsum);

  assign ridx_inc = (ridx == LAST_I) ? '0 : ridx + 1'b1;
  // Index parks on the consumed slot only when the queue ends up empty.
  assign hold_idx = ev.pop_last & ~ev.push;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      ridx  <= '0;
    end else if (rx_clr) begin
      count <= '0;
    end else begin
      count <= count + CW'(ev.push) - CW'(ev.pop);
      if (ev.pop && !hold_idx) ridx <= ridx_inc;
    end
  end

  // R1: never more than DEPTH pending
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= DEPTH_C);

  // R6: an offer with no free space does not grow the queue
  a_r6_drop_when_full: assert property (@(posedge clk) disable iff (rst)
    (offer && free == '0 && !take && !rx_clr) |=> $stable(count));

  // R5: a read of an empty queue moves nothing
  a_r5_empty_read_inert: assert property (@(posedge clk) disable iff (rst)
    (take && count == '0 && !offer && !rx_clr) |=> ($stable(count) && $stable(ridx)));

  // R9: clear empties the queue and keeps the index
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> (count == '0 && $stable(ridx)));
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags
  import rxq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    rx_clr,
  input  rxq_ev_t ev,
  input  logic    brk_evt,
  input  logic    brk_ack,
  output logic    rdy,
  output logic    rdy_irq,
  output logic    brk_stat,
  output logic    brk_irq
);
  logic rdy_n, brk_stat_n, brk_irq_n, brk_seen;

  // Ready follows arrivals into an empty queue and the read that drains it.
  always_comb begin
    if (rx_clr)           rdy_n = 1'b0;
    else if (ev.push)     rdy_n = 1'b1;
    else if (ev.pop_last) rdy_n = 1'b0;
    else                  rdy_n = rdy;
  end

  // A consuming read while break is marked converts the mark into a request.
  assign brk_seen   = ev.pop & brk_stat;
  assign brk_stat_n = brk_evt ? 1'b1 : (brk_seen ? 1'b0 : brk_stat);
  assign brk_irq_n  = (brk_irq & ~brk_ack) | (brk_evt & ~brk_stat) | brk_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy      <= 1'b0;
      rdy_irq  <= 1'b0;
      brk_stat <= 1'b0;
      brk_irq  <= 1'b0;
    end else begin
      rdy      <= rdy_n;
      rdy_irq  <= rdy_n;
      brk_stat <= brk_stat_n;
      brk_irq  <= brk_irq_n;
    end
  end

  // R3: an accepted arrival leaves ready set
  a_r3_push_sets_ready: assert property (@(posedge clk) disable iff (rst)
    ev.push |=> (rdy && rdy_irq));

  // R7: a break strobe always marks the status bit
  a_r7_break_marks: assert property (@(posedge clk) disable iff (rst)
    brk_evt |=> brk_stat);

  // R8: consuming the marked data clears the mark and raises the request
  a_r8_read_converts_break: assert property (@(posedge clk) disable iff (rst)
    (ev.pop && brk_stat && !brk_evt) |=> (!brk_stat && brk_irq));

  // R8: acknowledge with no competing set drops the request
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (brk_ack && !brk_evt && !(ev.pop && brk_stat)) |=> !brk_irq);
endmodule

// File: rtl/rx_brk_queue.sv
module rx_brk_queue
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3,
  parameter int DW    = 8,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rx_en,
  input  logic          rx_clr,
  input  logic          in_vld,
  input  logic [DW-1:0] in_data,
  input  logic          brk_evt,
  input  logic          rd_req,
  input  logic          brk_ack,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] free_slots,
  output logic          rdy,
  output logic          rdy_irq,
  output logic          brk_stat,
  output logic          brk_irq
);
  rxq_ev_t       ev;
  logic [CW-1:0] count;
  logic [IW-1:0] ridx, waddr;
  logic [DW-1:0] wdata;

  // A break takes the cycle and stores an all-zero character.
  assign wdata = brk_evt ? '0 : in_data;

  rxq_ptr #(.DEPTH(DEPTH), .IW(IW), .CW(CW)) u_ptr (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rx_clr(rx_clr),
    .offer(in_vld | brk_evt), .take(rd_req),
    .count(count), .ridx(ridx), .waddr(waddr), .free(free_slots), .ev(ev)
  );

  rxq_mem #(.DEPTH(DEPTH), .DW(DW), .IW(IW)) u_mem (
    .clk(clk), .we(ev.push), .waddr(waddr), .wdata(wdata),
    .re(rd_req), .raddr(ridx), .rdata(rd_data)
  );

  rxq_flags u_flags (
    .clk(clk), .rst(rst), .rx_clr(rx_clr), .ev(ev),
    .brk_evt(brk_evt), .brk_ack(brk_ack),
    .rdy(rdy), .rdy_irq(rdy_irq), .brk_stat(brk_stat), .brk_irq(brk_irq)
  );

  // R4: ready status agrees with the pointer logic's count
  a_r4_ready_matches_count: assert property (@(posedge clk) disable iff (rst)
    rdy == (count != '0));
endmodule

// File: tb/sim_rx_brk_queue.sv
`timescale 1ns/1ps
module sim_rx_brk_queue;
  localparam int DEP = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic b_en = 1'b0, b_clr = 1'b0, b_vld = 1'b0, b_brk = 1'b0, b_rd = 1'b0, b_ack = 1'b0;
  logic [7:0] b_din = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] free_slots;
  logic rdy, rdy_irq, brk_stat, brk_irq;

  int vectors = 0;
  int miscompares = 0;
  string phase = "reset";

  // behavioural reference state
  int m_mem [DEP] = '{-1, -1, -1};
  int m_idx = 0, m_cnt = 0, m_rd = -1;
  bit m_rdy = 0, m_ri = 0, m_bs = 0, m_bi = 0;
  string m_rd_req = "R4";

  always #10 clk = ~clk;

  rx_brk_queue u0 (
    .clk(clk), .rst(rst), .rx_en(b_en), .rx_clr(b_clr), .in_vld(b_vld),
    .in_data(b_din), .brk_evt(b_brk), .rd_req(b_rd), .brk_ack(b_ack),
    .rd_data(rd_data), .free_slots(free_slots), .rdy(rdy), .rdy_irq(rdy_irq),
    .brk_stat(brk_stat), .brk_irq(brk_irq)
  );

  always @(posedge clk) begin
    int fr, nc;
    bit psh, pp, bseen;
    if (b_rd) m_rd = m_mem[m_idx];
    if (rst) begin
      m_cnt = 0; m_idx = 0; m_rdy = 0; m_ri = 0; m_bs = 0; m_bi = 0;
    end else begin
      fr    = b_en ? DEP - m_cnt : 0;
      psh   = (b_brk || b_vld) && fr > 0 && !b_clr;
      pp    = b_rd && m_cnt > 0 && !b_clr;
      if (b_rd) m_rd_req = pp ? "R4" : "R5";
      bseen = pp && m_bs;
      m_bi  = (m_bi && !b_ack) || (b_brk && !m_bs) || bseen;
      m_bs  = b_brk ? 1'b1 : (bseen ? 1'b0 : m_bs);
      if (psh) m_mem[(m_idx + m_cnt) % DEP] = b_brk ? 0 : int'(b_din);
      nc = b_clr ? 0 : m_cnt + int'(psh) - int'(pp);
      if (pp && nc != 0) m_idx = (m_idx + 1) % DEP;
      m_cnt = nc;
      m_rdy = (nc != 0);
      m_ri  = (nc != 0);
    end
  end

  task automatic chk(string sig, string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s [%s] got %0d expected %0d", req, sig, phase, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("free_slots", "R2", int'(free_slots), b_en ? DEP - m_cnt : 0);
    chk("rdy", "R3", int'(rdy), int'(m_rdy));
    chk("rdy_irq", "R3", int'(rdy_irq), int'(m_ri));
    chk("brk_stat", "R7", int'(brk_stat), int'(m_bs));
    chk("brk_irq", "R8", int'(brk_irq), int'(m_bi));
    if (m_rd >= 0) chk("rd_data", m_rd_req, int'(rd_data), m_rd);
  endtask

  // one clock: drive after the falling edge, compare at the next falling edge
  task automatic cyc(bit en, bit clr, bit vld, logic [7:0] d, bit brk, bit rd, bit ack);
    b_en = en; b_clr = clr; b_vld = vld; b_din = d; b_brk = brk; b_rd = rd; b_ack = ack;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic push(logic [7:0] d);  cyc(1, 0, 1, d, 0, 0, 0); endtask
  task automatic pull();               cyc(1, 0, 0, 8'h00, 0, 1, 0); endtask
  task automatic idle();               cyc(1, 0, 0, 8'h00, 0, 0, 0); endtask

  initial begin
    repeat (50000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired in phase %s", phase);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) cyc(0, 0, 0, 8'h00, 0, 0, 0);
    rst = 1'b0;
    phase = "R2 reset state and disabled free space";
    cyc(0, 0, 0, 8'h00, 0, 0, 0);
    idle();

    phase = "R1 R3 order and index wrap";
    for (int k = 0; k < 4; k++) begin
      push(8'h10 + 8'(k));
      push(8'h20 + 8'(k));
      push(8'h30 + 8'(k));
      pull(); pull(); idle();
      pull(); idle();
    end

    phase = "R6 full and disabled drops";
    push(8'hA1); push(8'hA2); push(8'hA3);
    push(8'hEE);
    cyc(0, 0, 1, 8'hEF, 0, 0, 0);
    pull(); pull(); pull(); idle();

    phase = "R5 empty read is inert";
    pull(); idle(); pull(); idle();

    phase = "R10 read with arrival at counts 0 1 3";
    cyc(1, 0, 1, 8'h55, 0, 1, 0);
    idle();
    cyc(1, 0, 1, 8'h66, 0, 1, 0);
    idle();
    push(8'h67); push(8'h68);
    cyc(1, 0, 1, 8'h69, 0, 1, 0);
    pull(); pull(); pull(); idle();

    phase = "R7 break inserts zero";
    push(8'h77);
    cyc(1, 0, 1, 8'hBB, 1, 0, 0);
    cyc(1, 0, 0, 8'h00, 1, 0, 0);
    cyc(1, 0, 0, 8'h00, 0, 0, 1);
    idle();

    phase = "R8 consuming read converts break";
    pull(); idle();
    cyc(1, 0, 0, 8'h00, 0, 0, 1);
    cyc(1, 0, 0, 8'h00, 1, 1, 0);
    cyc(1, 0, 0, 8'h00, 0, 1, 1);
    pull(); pull(); idle();
    cyc(1, 0, 0, 8'h00, 0, 0, 1);

    phase = "R9 clear with concurrent traffic";
    push(8'h91); push(8'h92);
    cyc(1, 1, 1, 8'h93, 0, 1, 0);
    idle(); pull(); idle();
    push(8'h94); pull(); idle();

    phase = "R10 mixed traffic";
    for (int k = 0; k < 3000; k++) begin
      cyc(($urandom % 10) != 0, ($urandom % 40) == 0, ($urandom % 5) < 2,
          8'($urandom), ($urandom % 20) == 0, ($urandom % 5) < 2, ($urandom % 8) == 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule